// File: doc/BRIEF.md
# LCD Controller Control and Status Core

This block is the control and status core of a raster LCD controller. It holds a control word and a status word, and it drives one registered interrupt line. The control word carries an enable bit, a two-bit load-mode field and six interrupt mask bits. The status word records these events:

- end of scanning
- palette fetch complete
- vertical sync
- line match
- FIFO underflow
- loss of sync

The pixel path, the fetch engine and the panel timing counters lie outside the block. The fetch engine reports `pal_done` when a palette transfer ends. The timing generator takes a one-cycle `frame_start` request and answers with a `frame_end` pulse. Its other events come in as single-cycle pulses.

Software starts the block by setting enable. It stops the block by clearing enable, and the stop is graceful: the frame that is running finishes before the done flag rises. Each status bit has its own clearing rule:

- Vsync and line-match are cleared by a software write.
- Underflow and sync-loss are cleared by disabling the controller.
- Palette-loaded is cleared by a write in palette-only mode, and by disabling in the other modes.
- Done is cleared by enabling the controller again.

If a status bit sees its set event and its clear in the same cycle, the bit stays set.

Top module: `lcd_ctrl_core`

## Requirements
- R1: After reset, `ctrl_q`, `stat_q`, `irq` and `frame_start` are all zero.
- R2: Control layout: bit 0 is enable, bits [2:1] are the load mode, and bits [8:3] are the masks for status bits [5:0]. A write to the control word is read back unchanged on `ctrl_q` one edge later, unless the controller turns itself off at that edge (see R6).
- R3: With enable set in load mode 2'b10 (frame only) or 2'b00 (treated as frame only), `frame_start` pulses for one cycle on the second edge after the enabling write. After each `frame_end` it pulses again on the second edge, for as long as enable stays set.
- R4: Clearing enable during a frame does not set done (status bit 0) until `frame_end`. Done is set on the `frame_end` edge, and no further `frame_start` follows.
- R5: Done stays set through status writes. The enabling control write clears it on the edge at which that write is taken.
- R6: In load mode 2'b01 (palette only), no `frame_start` is issued. On `pal_done` the palette-loaded bit (status bit 1) and done are set, and the enable bit is cleared by the controller itself.
- R7: In load mode 2'b11 (palette then frame), `frame_start` is asserted in the cycle right after the `pal_done` edge, and the palette-loaded bit is set on that same edge.
- R8: Underflow (status bit 4) and sync-lost (status bit 5) are set by `ev_underflow` and `ev_synclost`. Status writes do not clear them. The edge at which enable goes from 1 to 0 clears them.
- R9: A status write with bit 1 at zero clears palette-loaded only in mode 2'b01. In the other modes such a write has no effect, and the enable 1-to-0 edge clears the bit.
- R10: Vsync (status bit 2) and line (status bit 3) are set by `ev_vsync` and `ev_line`. A status write with the bit at zero clears it, and a write with the bit at one keeps it.
- R11: `irq` equals the OR of `stat_q & ctrl_q[8:3]`, registered one edge later. The done mask keeps working while enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 9 | Control word write data |
| ctrl_q | output | 9 | Control word readback |
| stat_we | input | 1 | Status word write strobe |
| stat_wdata | input | 6 | Status write data (a zero in a writable bit clears that bit) |
| stat_q | output | 6 | Status word |
| pal_done | input | 1 | Palette transfer complete pulse |
| frame_end | input | 1 | End of frame pulse from the timing generator |
| ev_vsync | input | 1 | Vertical sync event pulse |
| ev_line | input | 1 | Line match event pulse |
| ev_underflow | input | 1 | FIFO underflow event pulse |
| ev_synclost | input | 1 | Sync loss event pulse |
| frame_start | output | 1 | One-cycle request to start a frame |
| irq | output | 1 | Registered interrupt |

## Verification
A wrong scan state shows up at the ports within one or two edges:

- A missing or doubled `frame_start` shows up right after an enabling write or a `frame_end`.
- A done flag that rises before `frame_end` shows up in the cycles between the disabling write and the end of the frame.

The clearing rules are checked by applying each event, then a write or a disable, and reading `stat_q` on the next sample. This catches a bit that clears under the wrong rule, or fails to clear, in the same cycle. A mask or latency fault shows up as `irq` being one cycle early, one cycle late, or not moving at all.

// File: rtl/lcd_ctrl_core.sv
module lcd_ctrl_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [8:0] ctrl_wdata,
  output logic [8:0] ctrl_q,
  input  logic       stat_we,
  input  logic [5:0] stat_wdata,
  output logic [5:0] stat_q,
  input  logic       pal_done,
  input  logic       frame_end,
  input  logic       ev_vsync,
  input  logic       ev_line,
  input  logic       ev_underflow,
  input  logic       ev_synclost,
  output logic       frame_start,
  output logic       irq
);

  typedef enum logic [1:0] {S_IDLE, S_PAL, S_SCAN} state_t;

  state_t      st;
  logic        en;
  logic [1:0]  mode;
  logic [5:0]  mask;
  logic [5:0]  stat;
  logic        fs_q;
  logic        irq_q;

  logic        pal_first, pal_only, pal_end, scan_end;
  logic        self_off, en_d, en_fall, en_rise, done_set;
  logic [5:0]  set_v, wr_clr, dis_clr, stat_d;

  assign pal_first = mode[0];
  assign pal_only  = (mode == 2'b01);
  assign pal_end   = (st == S_PAL)  && pal_done;
  assign scan_end  = (st == S_SCAN) && frame_end;
  assign self_off  = pal_end && pal_only;

  assign en_d    = ctrl_we ? ctrl_wdata[0] : (en && !self_off);
  assign en_fall = en && !en_d;
  assign en_rise = !en && en_d;

  assign done_set = ((scan_end && !en) || (pal_end && (pal_only || !en))) && !en_rise;

  assign set_v   = {ev_synclost, ev_underflow, ev_line, ev_vsync, pal_end, done_set};
  assign wr_clr  = {6{stat_we}} & ~stat_wdata & {4'b0011, pal_only, 1'b0};
  assign dis_clr = {en_fall, en_fall, 2'b00, en_fall && !pal_only, en_rise};
  assign stat_d  = (stat & ~(wr_clr | dis_clr)) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= 2'b00;
      mask <= '0;
    end else begin
      en <= en_d;
      if (ctrl_we) begin
        mode <= ctrl_wdata[2:1];
        mask <= ctrl_wdata[8:3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      fs_q <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      unique case (st)
        S_IDLE:
          if (en) begin
            if (pal_first) st <= S_PAL;
            else begin
              st   <= S_SCAN;
              fs_q <= 1'b1;
            end
          end
        S_PAL:
          if (pal_done) begin
            if (!pal_only && en) begin
              st   <= S_SCAN;
              fs_q <= 1'b1;
            end else st <= S_IDLE;
          end
        S_SCAN:
          if (frame_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      irq_q <= 1'b0;
    end else begin
      stat  <= stat_d;
      irq_q <= |(stat & mask);
    end
  end

  assign ctrl_q      = {mask, mode, en};
  assign stat_q      = stat;
  assign frame_start = fs_q;
  assign irq         = irq_q;

endmodule

// File: rtl/lcd_ctrl_core_chk.sv
module lcd_ctrl_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_we,
  input logic [8:0] ctrl_q,
  input logic [5:0] stat_q,
  input logic       frame_start,
  input logic       irq
);

  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(ctrl_q[0]));

  a_r4_done_only_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> !ctrl_q[0]);

  a_r5_done_clear_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[0]) |-> $rose(ctrl_q[0]));

  a_r8_underflow_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[4]) |-> $fell(ctrl_q[0]));

  a_r8_synclost_clear_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[5]) |-> $fell(ctrl_q[0]));

  a_r10_vsync_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[2]) |-> $past(stat_we));

  a_r10_line_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[3]) |-> $past(stat_we));

  a_r11_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ctrl_q[8:3])) |=> irq);

  a_r11_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & ctrl_q[8:3])) |=> !irq);

endmodule

bind lcd_ctrl_core lcd_ctrl_core_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .stat_we(stat_we),
  .ctrl_q(ctrl_q),
  .stat_q(stat_q),
  .frame_start(frame_start),
  .irq(irq)
);

// File: tb/tb_lcd_ctrl_core.sv
`timescale 1ns/1ps
module tb_lcd_ctrl_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [8:0] ctrl_wdata = '0;
  logic [8:0] ctrl_q;
  logic       stat_we = 1'b0;
  logic [5:0] stat_wdata = '0;
  logic [5:0] stat_q;
  logic       pal_done = 1'b0;
  logic       frame_end = 1'b0;
  logic       ev_vsync = 1'b0;
  logic       ev_line = 1'b0;
  logic       ev_underflow = 1'b0;
  logic       ev_synclost = 1'b0;
  logic       frame_start;
  logic       irq;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  lcd_ctrl_core dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .pal_done(pal_done), .frame_end(frame_end),
    .ev_vsync(ev_vsync), .ev_line(ev_line),
    .ev_underflow(ev_underflow), .ev_synclost(ev_synclost),
    .frame_start(frame_start), .irq(irq)
  );

  // vector: {events {synclost,underflow,line,vsync}, status write, write data, expected status}
  localparam logic [16:0] VEC [7] = '{
    {4'b0001, 1'b0, 6'b000000, 6'b000100},
    {4'b0010, 1'b0, 6'b000000, 6'b001100},
    {4'b0000, 1'b1, 6'b111011, 6'b001000},
    {4'b1100, 1'b0, 6'b000000, 6'b111000},
    {4'b0000, 1'b1, 6'b000000, 6'b110000},
    {4'b0101, 1'b0, 6'b000000, 6'b110100},
    {4'b0000, 1'b1, 6'b110000, 6'b110000}
  };

  function automatic logic [8:0] cv(logic [5:0] m, logic [1:0] md, logic e);
    return {m, md, e};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [8:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_stat(logic [5:0] d);
    @(negedge clk); stat_we = 1'b1; stat_wdata = d;
    @(negedge clk); stat_we = 1'b0;
  endtask

  task automatic pulse_fe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic pulse_pd();
    @(negedge clk); pal_done = 1'b1;
    @(negedge clk); pal_done = 1'b0;
  endtask

  task automatic idle_chk_no_start(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, frame_start, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 stat", stat_q, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", frame_start, 0);

    for (int v = 0; v < 7; v++) begin
      @(negedge clk);
      {ev_synclost, ev_underflow, ev_line, ev_vsync} = VEC[v][16:13];
      @(negedge clk);
      {ev_synclost, ev_underflow, ev_line, ev_vsync} = 4'b0000;
      if (VEC[v][12]) wr_stat(VEC[v][11:6]);
      chk("R10 table", stat_q, VEC[v][5:0]);
    end
    chk("R11 masked", irq, 0);

    wr_ctrl(cv(6'b000001, 2'b10, 1'b1));
    chk("R2 readback", ctrl_q, cv(6'b000001, 2'b10, 1'b1));
    chk("R3 no start yet", frame_start, 0);
    @(negedge clk); chk("R3 start", frame_start, 1);
    @(negedge clk); chk("R3 one cycle", frame_start, 0);

    wr_ctrl(cv(6'b000001, 2'b10, 1'b0));
    chk("R8 disable clears faults", stat_q[5:4], 0);
    chk("R4 no early done", stat_q[0], 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 done waits frame", stat_q[0], 0);
    end
    pulse_fe();
    chk("R4 done at frame end", stat_q[0], 1);
    chk("R11 latency", irq, 0);
    @(negedge clk);
    chk("R11 done mask while off", irq, 1);
    idle_chk_no_start("R4 no restart", 3);

    wr_stat(6'b000000);
    chk("R5 write keeps done", stat_q[0], 1);
    wr_ctrl(cv(6'b000000, 2'b00, 1'b1));
    chk("R5 enable clears done", stat_q[0], 0);
    @(negedge clk); chk("R3 mode00 start", frame_start, 1);
    pulse_fe();
    chk("R3 gap", frame_start, 0);
    @(negedge clk); chk("R3 restart", frame_start, 1);
    wr_ctrl(cv(6'b000000, 2'b00, 1'b0));
    pulse_fe();
    chk("R4 done again", stat_q[0], 1);

    wr_ctrl(cv(6'b000010, 2'b01, 1'b1));
    chk("R5 clear on palette enable", stat_q[0], 0);
    idle_chk_no_start("R6 no start", 4);
    pulse_pd();
    chk("R6 pal loaded", stat_q[1], 1);
    chk("R6 done", stat_q[0], 1);
    chk("R6 self disable", ctrl_q[0], 0);
    @(negedge clk);
    chk("R11 pal mask", irq, 1);
    chk("R6 no start after", frame_start, 0);
    wr_stat(6'b111101);
    chk("R9 write clear pal-only", stat_q[1], 0);

    wr_ctrl(cv(6'b000000, 2'b11, 1'b1));
    chk("R5 clear mode11", stat_q[0], 0);
    idle_chk_no_start("R7 wait palette", 2);
    pulse_pd();
    chk("R7 pal loaded", stat_q[1], 1);
    chk("R7 start after palette", frame_start, 1);
    @(negedge clk); ev_underflow = 1'b1;
    @(negedge clk); ev_underflow = 1'b0;
    chk("R8 underflow set", stat_q[4], 1);
    wr_stat(6'b000000);
    chk("R8 write keeps underflow", stat_q[4], 1);
    chk("R9 write keeps pal mode11", stat_q[1], 1);
    wr_ctrl(cv(6'b000000, 2'b11, 1'b0));
    chk("R9 disable clears pal", stat_q[1], 0);
    chk("R8 disable clears underflow", stat_q[4], 0);
    pulse_fe();
    chk("R4 done mode11", stat_q[0], 1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule